// File: doc/BRIEF.md
# SCSI Controller Host Register Port

This block sits between a host processor and the rest of a SCSI protocol controller. It decodes eight register addresses. The host reaches them through an active-low select, active-low read and write strobes, and a 3-bit address. A given address selects different things on read and on write. Some addresses hold configuration bytes. Some return live bus state that the controller supplies. Some are actions: a start-DMA command on write, or a clear of the parity and interrupt flags on read.

The strobes are brought into the internal clock domain through synchronising flops. Each access is acted on once, at the clock where its strobe is first seen active. Address and write data are taken from the pins at that clock, so the host must hold them steady for the whole strobe. Stored bytes go out to the controller as plain register outputs, and actions go out as single-clock pulses. Read data is registered. It is presented together with an enable for the host data bus driver, and that enable is raised only during a valid read. The block carries data bytes through unchanged and never interprets them.

Top module: `scsi_host_regs`

## Requirements
- R1: While `rst` is high at a clock edge, every stored byte, every action pulse, `cpu_d_oe` and `cpu_d_out` are 0 after that edge.
- R2: An access counts only when `cs_n` is low and exactly one of `rd_n`/`wr_n` is low. With `cs_n` high, strobe activity changes no stored byte, raises no pulse and leaves `cpu_d_oe` low.
- R3: A write to address 0 stores the write byte unchanged, for all 256 values, and shows it on `out_data_q`.
- R4: Addresses 1, 2 and 3 are read/write bytes (`icmd_q`, `mode_q`, `tcmd_q`). A read returns the last byte written to the same address.
- R5: A write to address 4 stores the byte on `sel_en_q`. A read at address 4 returns the `bus_status` input instead.
- R6: A read at address 0 returns `scsi_data_live`, at 5 returns `bus_and_status`, at 6 returns `in_data`, and at 7 returns 0x00.
- R7: A write to address 5, 6 or 7 raises `dma_send_p`, `dma_trx_p` or `dma_irx_p` respectively. The pulse is exactly one clock wide, occurs once per access, and changes no stored byte.
- R8: A read at address 7 raises `clr_flags_p` for exactly one clock per access. Reads at other addresses raise no pulse.
- R9: `cpu_d_oe` is high only while a valid read is in progress. When it is low, `cpu_d_out` is 0.
- R10: At most one action pulse is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 3 | Register address |
| cpu_d_in | input | 8 | Host write data |
| cpu_d_out | output | 8 | Host read data |
| cpu_d_oe | output | 1 | Host data bus driver enable |
| scsi_data_live | input | 8 | Live SCSI data bus value |
| bus_status | input | 8 | Current bus signal status |
| bus_and_status | input | 8 | Bus-and-status flags |
| in_data | input | 8 | Latched input data byte |
| out_data_q | output | 8 | Output data byte |
| icmd_q | output | 8 | Initiator command byte |
| mode_q | output | 8 | Mode byte |
| tcmd_q | output | 8 | Target command byte |
| sel_en_q | output | 8 | Select-enable byte |
| dma_send_p | output | 1 | Start DMA send pulse |
| dma_trx_p | output | 1 | Start DMA target receive pulse |
| dma_irx_p | output | 1 | Start DMA initiator receive pulse |
| clr_flags_p | output | 1 | Clear parity/interrupt flags pulse |

## Verification
The assertions check these properties on every clock:
- every action pulse is one clock wide;
- no two pulses are high together;
- a start-DMA pulse never coincides with a change to a stored byte;
- the read bus is zero whenever its driver enable is low;
- a flag-clear pulse comes only with an enabled read.

The bench scenarios cover what the assertions cannot see:
- every byte value written to each storing address and read back;
- the read/write split at addresses 0 and 4;
- exactly one pulse per held-low strobe;
- that strobes without chip select leave every register untouched.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int SHR_ADDR_W = 3;
  localparam int SHR_DATA_W = 8;

  typedef enum logic [SHR_ADDR_W-1:0] {
    A_DATA   = 3'd0,
    A_ICMD   = 3'd1,
    A_MODE   = 3'd2,
    A_TCMD   = 3'd3,
    A_STATUS = 3'd4,
    A_BSTAT  = 3'd5,
    A_INDATA = 3'd6,
    A_CLEAR  = 3'd7
  } shr_addr_e;
endpackage

// File: rtl/shr_sync.sv
module shr_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/shr_access_dec.sv
module shr_access_dec #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_act,
  output logic rd_edge,
  output logic wr_edge
);
  logic [2:0] pins_s;
  logic       rd_act_d, wr_act_d, wr_act;

  shr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rd_n, wr_n}),
    .q   (pins_s)
  );

  // a valid cycle needs select plus exactly one strobe
  assign rd_act = !pins_s[2] && !pins_s[1] &&  pins_s[0];
  assign wr_act = !pins_s[2] &&  pins_s[1] && !pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_d <= 1'b0;
      wr_act_d <= 1'b0;
    end else begin
      rd_act_d <= rd_act;
      wr_act_d <= wr_act;
    end
  end

  assign rd_edge = rd_act && !rd_act_d;
  assign wr_edge = wr_act && !wr_act_d;
endmodule

// File: rtl/shr_reg_bank.sv
module shr_reg_bank
  import shr_pkg::*;
#(
  parameter int DW = SHR_DATA_W,
  parameter int AW = SHR_ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_edge,
  input  logic          rd_edge,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_data_q,
  output logic [DW-1:0] icmd_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcmd_q,
  output logic [DW-1:0] sel_en_q,
  output logic          dma_send_p,
  output logic          dma_trx_p,
  output logic          dma_irx_p,
  output logic          clr_flags_p
);
  localparam int NSTORE = 5;
  localparam int NPULSE = 4;

  logic [DW-1:0] store_q [NSTORE];
  logic [NPULSE-1:0] pulse_q;

  // storing addresses 0..4 land in slots 0..4
  genvar i;
  generate
    for (i = 0; i < NSTORE; i++) begin : g_store
      always_ff @(posedge clk) begin
        if (rst) store_q[i] <= '0;
        else if (wr_edge && (addr == AW'(i))) store_q[i] <= wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= '0;
    else begin
      pulse_q[0] <= wr_edge && (addr == A_BSTAT);
      pulse_q[1] <= wr_edge && (addr == A_INDATA);
      pulse_q[2] <= wr_edge && (addr == A_CLEAR);
      pulse_q[3] <= rd_edge && (addr == A_CLEAR);
    end
  end

  assign out_data_q  = store_q[0];
  assign icmd_q      = store_q[1];
  assign mode_q      = store_q[2];
  assign tcmd_q      = store_q[3];
  assign sel_en_q    = store_q[4];
  assign dma_send_p  = pulse_q[0];
  assign dma_trx_p   = pulse_q[1];
  assign dma_irx_p   = pulse_q[2];
  assign clr_flags_p = pulse_q[3];

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse_q)); // R10
  AST_DMA_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (dma_send_p || dma_trx_p || dma_irx_p) |=> !(dma_send_p || dma_trx_p || dma_irx_p)); // R7
  AST_DMA_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (dma_send_p || dma_trx_p || dma_irx_p) |->
      $stable({out_data_q, icmd_q, mode_q, tcmd_q, sel_en_q})); // R7
  AST_CLEAR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    clr_flags_p |=> !clr_flags_p); // R8
endmodule

// File: rtl/shr_read_port.sv
module shr_read_port
  import shr_pkg::*;
#(
  parameter int DW = SHR_DATA_W,
  parameter int AW = SHR_ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_act,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] scsi_data_live,
  input  logic [DW-1:0] icmd_q,
  input  logic [DW-1:0] mode_q,
  input  logic [DW-1:0] tcmd_q,
  input  logic [DW-1:0] bus_status,
  input  logic [DW-1:0] bus_and_status,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] cpu_d_out,
  output logic          cpu_d_oe
);
  logic [DW-1:0] sel;

  always_comb begin
    unique case (shr_addr_e'(addr))
      A_DATA:   sel = scsi_data_live;
      A_ICMD:   sel = icmd_q;
      A_MODE:   sel = mode_q;
      A_TCMD:   sel = tcmd_q;
      A_STATUS: sel = bus_status;
      A_BSTAT:  sel = bus_and_status;
      A_INDATA: sel = in_data;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_d_out <= '0;
      cpu_d_oe  <= 1'b0;
    end else begin
      cpu_d_oe  <= rd_act;
      cpu_d_out <= rd_act ? sel : '0;
    end
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !cpu_d_oe |-> (cpu_d_out == '0)); // R9
endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
  import shr_pkg::*;
#(
  parameter int DW          = SHR_DATA_W,
  parameter int AW          = SHR_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] cpu_d_in,
  output logic [DW-1:0] cpu_d_out,
  output logic          cpu_d_oe,
  input  logic [DW-1:0] scsi_data_live,
  input  logic [DW-1:0] bus_status,
  input  logic [DW-1:0] bus_and_status,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] out_data_q,
  output logic [DW-1:0] icmd_q,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] tcmd_q,
  output logic [DW-1:0] sel_en_q,
  output logic          dma_send_p,
  output logic          dma_trx_p,
  output logic          dma_irx_p,
  output logic          clr_flags_p
);
  logic rd_act, rd_edge, wr_edge;

  shr_access_dec #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .rd_act  (rd_act),
    .rd_edge (rd_edge),
    .wr_edge (wr_edge)
  );

  shr_reg_bank #(.DW(DW), .AW(AW)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_edge     (wr_edge),
    .rd_edge     (rd_edge),
    .addr        (addr),
    .wdata       (cpu_d_in),
    .out_data_q  (out_data_q),
    .icmd_q      (icmd_q),
    .mode_q      (mode_q),
    .tcmd_q      (tcmd_q),
    .sel_en_q    (sel_en_q),
    .dma_send_p  (dma_send_p),
    .dma_trx_p   (dma_trx_p),
    .dma_irx_p   (dma_irx_p),
    .clr_flags_p (clr_flags_p)
  );

  shr_read_port #(.DW(DW), .AW(AW)) u_rd (
    .clk            (clk),
    .rst            (rst),
    .rd_act         (rd_act),
    .addr           (addr),
    .scsi_data_live (scsi_data_live),
    .icmd_q         (icmd_q),
    .mode_q         (mode_q),
    .tcmd_q         (tcmd_q),
    .bus_status     (bus_status),
    .bus_and_status (bus_and_status),
    .in_data        (in_data),
    .cpu_d_out      (cpu_d_out),
    .cpu_d_oe       (cpu_d_oe)
  );

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    clr_flags_p |-> cpu_d_oe); // R8
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (dma_send_p || dma_trx_p || dma_irx_p) |-> !cpu_d_oe); // R9
endmodule

// File: tb/scsi_host_regs_test.sv
module scsi_host_regs_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] cpu_d_in = '0;
  logic [7:0] scsi_data_live = '0, bus_status = '0, bus_and_status = '0, in_data = '0;
  logic [7:0] cpu_d_out, out_data_q, icmd_q, mode_q, tcmd_q, sel_en_q;
  logic cpu_d_oe, dma_send_p, dma_trx_p, dma_irx_p, clr_flags_p;

  int tests = 0, fails = 0;
  int n_send = 0, n_trx = 0, n_irx = 0, n_clr = 0;
  bit finished = 0;
  logic [7:0] sh [5];

  always #10 clk = ~clk;

  scsi_host_regs uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
    .scsi_data_live(scsi_data_live), .bus_status(bus_status),
    .bus_and_status(bus_and_status), .in_data(in_data),
    .out_data_q(out_data_q), .icmd_q(icmd_q), .mode_q(mode_q), .tcmd_q(tcmd_q),
    .sel_en_q(sel_en_q), .dma_send_p(dma_send_p), .dma_trx_p(dma_trx_p),
    .dma_irx_p(dma_irx_p), .clr_flags_p(clr_flags_p)
  );

  // pulse-cycle counters sampled mid-cycle
  always @(negedge clk) begin
    if (dma_send_p)  n_send++;
    if (dma_trx_p)   n_trx++;
    if (dma_irx_p)   n_irx++;
    if (clr_flags_p) n_clr++;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_store(string req);
    chk(req, out_data_q, sh[0]);
    chk(req, icmd_q, sh[1]);
    chk(req, mode_q, sh[2]);
    chk(req, tcmd_q, sh[3]);
    chk(req, sel_en_q, sh[4]);
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; cpu_d_in = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    if (a <= 3'd4) sh[a] = d;
  endtask

  task automatic do_read(logic [2:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    d = cpu_d_out; oe = cpu_d_oe;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    for (int k = 0; k < 5; k++) sh[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", out_data_q | icmd_q | mode_q | tcmd_q | sel_en_q, 8'h00);
    chk("R1", {4'h0, dma_send_p, dma_trx_p, dma_irx_p, clr_flags_p}, 8'h00);
    chk("R1", {cpu_d_oe, 7'h0} | cpu_d_out, 8'h00);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R3 R4 R5: full byte sweep of every storing address
    for (int v = 0; v < 256; v++) begin
      do_write(3'd0, 8'(v));
      do_write(3'd1, 8'(v));
      do_write(3'd2, ~8'(v));
      do_write(3'd3, 8'(v) ^ 8'h5A);
      do_write(3'd4, 8'(v + 1));
      chk("R3", out_data_q, 8'(v));
      chk("R5", sel_en_q, 8'(v + 1));
      do_read(3'd1, rd, oe); chk("R4", rd, 8'(v));
      do_read(3'd2, rd, oe); chk("R4", rd, ~8'(v));
      do_read(3'd3, rd, oe); chk("R4", rd, 8'(v) ^ 8'h5A);
    end
    chk("R8", 8'(n_send + n_trx + n_irx + n_clr), 8'h00);

    // R5 R6: read-only sources at addresses 0,4,5,6,7
    for (int p = 0; p < 8; p++) begin
      scsi_data_live = 8'(1 << p);
      bus_status     = ~8'(1 << p);
      bus_and_status = 8'(p * 37 + 3);
      in_data        = 8'(8'hC3 ^ p);
      do_read(3'd0, rd, oe); chk("R6", rd, 8'(1 << p));
      do_read(3'd4, rd, oe); chk("R5", rd, ~8'(1 << p));
      chk("R5", sel_en_q, sh[4]);
      do_read(3'd5, rd, oe); chk("R6", rd, 8'(p * 37 + 3));
      do_read(3'd6, rd, oe); chk("R6", rd, 8'(8'hC3 ^ p));
      chk("R9", {7'h0, oe}, 8'h01);
    end
    chk("R8", 8'(n_clr), 8'h00);

    // R8: clear on read at address 7, once per access
    for (int k = 1; k <= 3; k++) begin
      do_read(3'd7, rd, oe);
      chk("R6", rd, 8'h00);
      chk("R8", 8'(n_clr), 8'(k));
    end

    // R7: start-DMA writes pulse once and store nothing
    do_write(3'd5, 8'hA5);
    chk("R7", 8'(n_send), 8'h01); chk("R7", 8'(n_trx + n_irx), 8'h00); chk_store("R7");
    do_write(3'd6, 8'h3C);
    chk("R7", 8'(n_trx), 8'h01); chk("R7", 8'(n_send + n_irx), 8'h01); chk_store("R7");
    do_write(3'd7, 8'hFF);
    chk("R7", 8'(n_irx), 8'h01); chk("R7", 8'(n_send + n_trx), 8'h02); chk_store("R7");
    chk("R8", 8'(n_clr), 8'h03);

    // R2 R9: strobes without chip select do nothing
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      addr = 3'(a); cpu_d_in = 8'hEE; wr_n = 1'b0;
      repeat (5) @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R9", {7'h0, cpu_d_oe}, 8'h00);
      chk("R9", cpu_d_out, 8'h00);
      rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_store("R2");
    end
    chk("R2", 8'(n_send + n_trx + n_irx + n_clr), 8'h06);
    chk("R9", {7'h0, cpu_d_oe}, 8'h00);

    // R1: reset mid-run clears stored bytes
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 5; k++) sh[k] = 8'h00;
    chk_store("R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule